// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Mapper

This block sits between an 8-bit console's CPU and PPU buses and the ROM and RAM chips on a game cartridge. The CPU programs a window of sixteen write-only registers. From those registers the block translates every CPU access in the upper 32 KB into an address in a larger program ROM. Every PPU pattern fetch is translated into an address in a larger character ROM. The block also chooses which internal nametable page the console uses, and it gates a small scratch RAM behind a key byte.

Program ROM is handled in 8 KB pages. Three CPU windows can be switched, and the top window is tied to the last page. Character ROM is handled in 1 KB pages across eight PPU windows. The first four windows are switched in pairs: writing value V to a pair register maps page V and page V+1. The last four windows are switched one at a time. Nametable mirroring normally comes from a dedicated register. A static strap input can take it instead from the top bit of the two pair registers. The ROM and RAM arrays are outside this block; it only produces their addresses and enables.

Top module: `cart_mapper_top`

## Requirements
- R1: Only CPU writes (cpu_wr=1) with cpu_addr in 0x7EF0..0x7EFF update registers. Offsets 6..F are decoded in even/odd pairs, so both members of a pair write the same register. Writes elsewhere, and all reads, leave every register unchanged.
- R2: For a CPU address A in 0x8000..0xDFFF, prg_rom_addr = bank*8192 + A[12:0]. The bank comes from the register written at offsets A/B for A[14:13]=0, C/D for 1, and E/F for 2. prg_rom_ce = cpu_rd & A[15].
- R3: For A in 0xE000..0xFFFF, prg_rom_addr always uses page PRG_PAGES-1.
- R4: A write of V at offset 0 maps PPU windows 0 and 1 (ppu_addr[12:10] = 0, 1) to character pages V and V+1. Offset 1 does the same for windows 2 and 3. chr_rom_addr = page*1024 + ppu_addr[9:0], and chr_rom_ce = ~ppu_addr[13].
- R5: Writes at offsets 2, 3, 4 and 5 select the single page used by PPU windows 4, 5, 6 and 7.
- R6: Every bank number is reduced modulo its page count before it forms an address, including the value V+1, which is computed to 9 bits.
- R7: With alt_mirror=0, bit 0 of a write at offset 6/7 sets the mirroring. A 1 gives vertical (nt_a10 = ppu_addr[10]) and a 0 gives horizontal (nt_a10 = ppu_addr[11]).
- R8: With alt_mirror=1, writes at offset 6/7 have no effect. nt_a10 is bit 7 of the offset-0 register for nametable slots 0 and 1 (ppu_addr[11]=0), and bit 7 of the offset-1 register for slots 2 and 3.
- R9: The RAM is unlocked only while the key register (offset 8/9) holds exactly 0xA3. Any other value locks it.
- R10: ram_ce is 1 only for a CPU read or write in 0x7F00..0x7FFF while unlocked. ram_we = ram_ce & cpu_wr. ram_addr = cpu_addr[6:0], so address bit 7 is ignored.
- R11: Reset clears every bank register to page 0, sets horizontal mirroring and clears the key register, which leaves the RAM locked.
- R12: A register write takes effect on the outputs from the clock edge that captures it. Before that edge the old mapping is still in force. Address translation and RAM gating are combinational on the current bus inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_mirror | input | 1 | Static strap: take mirroring from the pair registers' bit 7 |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | PPU address bus |
| prg_rom_addr | output | 17 | Program ROM address (default parameters) |
| prg_rom_ce | output | 1 | Program ROM enable |
| chr_rom_addr | output | 17 | Character ROM address (default parameters) |
| chr_rom_ce | output | 1 | Character ROM enable for pattern-table fetches |
| nt_a10 | output | 1 | Nametable page select |
| ram_ce | output | 1 | Scratch RAM enable |
| ram_we | output | 1 | Scratch RAM write enable |
| ram_addr | output | 7 | Scratch RAM byte index |

## Verification
Register writes land at the rising edge that samples the write strobe. Every mapping check that follows a write is therefore placed one full cycle later, on the next low clock phase. A dedicated check samples the PPU output during the write cycle itself and expects the old page. The translated addresses, nametable select and RAM enables are combinational. For these, the driver sets the bus at a falling edge and queues the expected values. The monitor compares them one nanosecond later, in the same low phase, before any edge can move the state.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam logic [11:0] REG_WINDOW = 12'h7EF;
    localparam logic [7:0]  RAM_WINDOW = 8'h7F;
    localparam logic [7:0]  RAM_KEY    = 8'hA3;

    typedef struct packed {
        logic [1:0][7:0] chr_pair;
        logic [3:0][7:0] chr_single;
        logic            mirror_vert;
        logic [7:0]      ram_key;
        logic [2:0][7:0] prg_bank;
    } map_regs_t;

endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
    import mapper_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        alt_mirror,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output map_regs_t   regs_q
);

    map_regs_t regs_d;
    logic      wr_hit;

    assign wr_hit = wr_en && (addr[15:4] == REG_WINDOW);

    always_comb begin
        regs_d = regs_q;
        if (wr_hit) begin
            case (addr[3:0])
                4'h0, 4'h1: regs_d.chr_pair[addr[0]] = wdata;
                4'h2, 4'h3, 4'h4, 4'h5:
                    regs_d.chr_single[addr[1:0] - 2'd2] = wdata;
                4'h6, 4'h7: begin
                    if (!alt_mirror) regs_d.mirror_vert = wdata[0];
                end
                4'h8, 4'h9: regs_d.ram_key = wdata;
                4'hA, 4'hB: regs_d.prg_bank[0] = wdata;
                4'hC, 4'hD: regs_d.prg_bank[1] = wdata;
                default:    regs_d.prg_bank[2] = wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // R1
    outside_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(regs_q));

    // R9
    key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && addr[3:1] == 3'd4 && wdata == RAM_KEY) |=> (regs_q.ram_key == RAM_KEY));

    // R8
    alt_mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt_mirror |=> $stable(regs_q.mirror_vert));

    // R11
    reset_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_q.ram_key == 8'h00 && regs_q.prg_bank == '0));

endmodule

// File: rtl/mapper_prg_xlate.sv
module mapper_prg_xlate #(
    parameter int PRG_PAGES = 16,
    localparam int PRG_PAGE_W = $clog2(PRG_PAGES),
    localparam int PRG_AW = PRG_PAGE_W + 13
) (
    input  logic [2:0][7:0]     prg_bank,
    input  logic [14:0]         cpu_off,
    output logic [PRG_AW-1:0]   prg_addr
);

    localparam logic [PRG_PAGE_W-1:0] LAST_PAGE = PRG_PAGE_W'(PRG_PAGES - 1);

    logic [PRG_PAGE_W-1:0] page_sel [3];
    logic [PRG_PAGE_W-1:0] page;

    for (genvar b = 0; b < 3; b++) begin : g_bank
        assign page_sel[b] = PRG_PAGE_W'(int'(prg_bank[b]) % PRG_PAGES);
    end

    always_comb begin
        case (cpu_off[14:13])
            2'd0:    page = page_sel[0];
            2'd1:    page = page_sel[1];
            2'd2:    page = page_sel[2];
            default: page = LAST_PAGE;
        endcase
        prg_addr = {page, cpu_off[12:0]};
    end

endmodule

// File: rtl/mapper_chr_xlate.sv
module mapper_chr_xlate #(
    parameter int CHR_PAGES = 128,
    localparam int CHR_PAGE_W = $clog2(CHR_PAGES),
    localparam int CHR_AW = CHR_PAGE_W + 10
) (
    input  logic [1:0][7:0]     chr_pair,
    input  logic [3:0][7:0]     chr_single,
    input  logic                mirror_vert,
    input  logic                alt_mirror,
    input  logic [12:0]         ppu_off,
    output logic [CHR_AW-1:0]   chr_addr,
    output logic                nt_a10
);

    logic [8:0]            page_raw [8];
    logic [CHR_PAGE_W-1:0] page_sel [8];

    for (genvar w = 0; w < 8; w++) begin : g_win
        if (w < 4) begin : g_pair
            assign page_raw[w] = {1'b0, chr_pair[w/2]} + 9'(w % 2);
        end else begin : g_single
            assign page_raw[w] = {1'b0, chr_single[w-4]};
        end
        assign page_sel[w] = CHR_PAGE_W'(int'(page_raw[w]) % CHR_PAGES);
    end

    always_comb begin
        chr_addr = {page_sel[ppu_off[12:10]], ppu_off[9:0]};
        if (alt_mirror)       nt_a10 = chr_pair[ppu_off[11]][7];
        else if (mirror_vert) nt_a10 = ppu_off[10];
        else                  nt_a10 = ppu_off[11];
    end

endmodule

// File: rtl/cart_mapper_top.sv
module cart_mapper_top
    import mapper_pkg::*;
#(
    parameter int PRG_PAGES = 16,
    parameter int CHR_PAGES = 128,
    localparam int PRG_PAGE_W = $clog2(PRG_PAGES),
    localparam int PRG_AW = PRG_PAGE_W + 13,
    localparam int CHR_AW = $clog2(CHR_PAGES) + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_mirror,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [13:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic              prg_rom_ce,
    output logic [CHR_AW-1:0] chr_rom_addr,
    output logic              chr_rom_ce,
    output logic              nt_a10,
    output logic              ram_ce,
    output logic              ram_we,
    output logic [6:0]        ram_addr
);

    map_regs_t regs;
    logic      ram_open;

    mapper_regfile i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .alt_mirror (alt_mirror),
        .wr_en      (cpu_wr),
        .addr       (cpu_addr),
        .wdata      (cpu_wdata),
        .regs_q     (regs)
    );

    mapper_prg_xlate #(.PRG_PAGES(PRG_PAGES)) i_prg (
        .prg_bank (regs.prg_bank),
        .cpu_off  (cpu_addr[14:0]),
        .prg_addr (prg_rom_addr)
    );

    mapper_chr_xlate #(.CHR_PAGES(CHR_PAGES)) i_chr (
        .chr_pair    (regs.chr_pair),
        .chr_single  (regs.chr_single),
        .mirror_vert (regs.mirror_vert),
        .alt_mirror  (alt_mirror),
        .ppu_off     (ppu_addr[12:0]),
        .chr_addr    (chr_rom_addr),
        .nt_a10      (nt_a10)
    );

    always_comb begin
        ram_open   = (regs.ram_key == RAM_KEY);
        prg_rom_ce = cpu_rd && cpu_addr[15];
        chr_rom_ce = !ppu_addr[13];
        ram_ce     = (cpu_rd || cpu_wr) && (cpu_addr[15:8] == RAM_WINDOW) && ram_open;
        ram_we     = ram_ce && cpu_wr;
        ram_addr   = cpu_addr[6:0];
    end

    // R3
    fixed_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (prg_rom_addr[PRG_AW-1:13] == PRG_PAGE_W'(PRG_PAGES - 1)));

    // R10
    ram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce |-> (cpu_addr[15:8] == RAM_WINDOW && regs.ram_key == RAM_KEY));

    // R10
    ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_ce && cpu_wr));

    // R2
    prg_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prg_rom_ce |-> cpu_addr[15]);

endmodule

// File: tb/test_cart_mapper_top.sv
`timescale 1ns/1ps
module test_cart_mapper_top;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        alt_mirror = 0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 0;
    logic        cpu_wr = 0;
    logic [13:0] ppu_addr = '0;
    logic [16:0] prg_rom_addr;
    logic        prg_rom_ce;
    logic [16:0] chr_rom_addr;
    logic        chr_rom_ce;
    logic        nt_a10;
    logic        ram_ce;
    logic        ram_we;
    logic [6:0]  ram_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cart_mapper_top i_cart_mapper_top (
        .clk(clk), .rst_n(rst_n), .alt_mirror(alt_mirror),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr), .prg_rom_ce(prg_rom_ce),
        .chr_rom_addr(chr_rom_addr), .chr_rom_ce(chr_rom_ce), .nt_a10(nt_a10),
        .ram_ce(ram_ce), .ram_we(ram_we), .ram_addr(ram_addr)
    );

    typedef enum int {F_PRG, F_PRG_CE, F_CHR, F_CHR_CE, F_NT, F_RAM_CE, F_RAM_WE, F_RAM_ADDR} field_t;
    typedef struct { field_t sel; int exp; string req; } item_t;
    item_t q[$];
    item_t cur;
    int    act;

    // monitor: compare queued expectations in the low phase
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            cur = q.pop_front();
            case (cur.sel)
                F_PRG:      act = int'(prg_rom_addr);
                F_PRG_CE:   act = int'(prg_rom_ce);
                F_CHR:      act = int'(chr_rom_addr);
                F_CHR_CE:   act = int'(chr_rom_ce);
                F_NT:       act = int'(nt_a10);
                F_RAM_CE:   act = int'(ram_ce);
                F_RAM_WE:   act = int'(ram_we);
                default:    act = int'(ram_addr);
            endcase
            checks++;
            if (act != cur.exp) begin
                errors++;
                $display("FAIL %s field %s: actual 0x%0h expected 0x%0h", cur.req, cur.sel.name(), act, cur.exp);
            end
        end
    end

    task automatic expect_val(field_t s, int e, string r);
        item_t it;
        it.sel = s; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic do_reset(bit alt);
        @(negedge clk);
        rst_n = 0; cpu_wr = 0; cpu_rd = 0; alt_mirror = alt;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic do_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1; cpu_rd = 0;
        @(posedge clk);
        #1 cpu_wr = 0;
    endtask

    task automatic chk_prg(logic [15:0] a, int exp, string r);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1; cpu_wr = 0;
        expect_val(F_PRG, exp, r);
        expect_val(F_PRG_CE, 1, r);
        #2;
    endtask

    task automatic chk_chr(logic [13:0] p, int exp, string r);
        @(negedge clk);
        ppu_addr = p;
        expect_val(F_CHR, exp, r);
        expect_val(F_CHR_CE, 1, r);
        #2;
    endtask

    task automatic chk_nt(logic [13:0] p, int exp, string r);
        @(negedge clk);
        ppu_addr = p;
        expect_val(F_NT, exp, r);
        expect_val(F_CHR_CE, 0, r);
        #2;
    endtask

    task automatic chk_ram(logic [15:0] a, bit rd, bit wr, int ce, int we, string r);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'h5A;
        expect_val(F_RAM_CE, ce, r);
        expect_val(F_RAM_WE, we, r);
        expect_val(F_RAM_ADDR, int'(a[6:0]), r);
        #2;
        cpu_wr = 0;
    endtask

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(0);
        // R11 reset state, R3 fixed page
        chk_prg(16'h8123, 'h00123, "R11");
        chk_prg(16'hE456, 15*8192 + 'h456, "R3");
        chk_chr(14'h0400, 'h0400, "R11");
        chk_chr(14'h1C00, 'h0000, "R11");
        chk_nt(14'h2800, 1, "R11");
        chk_nt(14'h2400, 0, "R11");
        chk_ram(16'h7F10, 1, 0, 0, 0, "R11");

        // R2 program windows, R6 wrap
        do_write(16'h7EFA, 8'h03);
        do_write(16'h7EFD, 8'h05);
        do_write(16'h7EFE, 8'h13);
        chk_prg(16'h8010, 3*8192 + 'h10, "R2");
        chk_prg(16'hA001, 5*8192 + 1, "R2");
        chk_prg(16'hC002, 3*8192 + 2, "R6");
        chk_prg(16'hFFFF, 'h1FFFF, "R3");
        do_write(16'h7EFB, 8'h07);
        chk_prg(16'h8000, 7*8192, "R1");

        // R1 writes outside the window and reads inside it change nothing
        do_write(16'h7EEA, 8'h09);
        do_write(16'h6EFA, 8'h09);
        @(negedge clk); cpu_addr = 16'h7EFA; cpu_wdata = 8'h02; cpu_rd = 1;
        chk_prg(16'h8000, 7*8192, "R1");

        // R4 pairs, R6 V+1 wrap
        do_write(16'h7EF0, 8'h10);
        chk_chr(14'h0000, 'h10*1024, "R4");
        chk_chr(14'h0405, 'h11*1024 + 5, "R4");
        do_write(16'h7EF1, 8'hFF);
        chk_chr(14'h0800, 127*1024, "R6");
        chk_chr(14'h0C00, 0, "R6");

        // R5 single windows
        do_write(16'h7EF2, 8'h20);
        do_write(16'h7EF3, 8'h21);
        do_write(16'h7EF4, 8'h22);
        do_write(16'h7EF5, 8'h23);
        chk_chr(14'h1000, 'h20*1024, "R5");
        chk_chr(14'h1400, 'h21*1024, "R5");
        chk_chr(14'h1800, 'h22*1024, "R5");
        chk_chr(14'h1C3F, 'h23*1024 + 'h3F, "R5");

        // R12 old mapping during the write cycle, new after the edge
        @(negedge clk);
        cpu_addr = 16'h7EF2; cpu_wdata = 8'h30; cpu_wr = 1; ppu_addr = 14'h1000;
        expect_val(F_CHR, 'h20*1024, "R12");
        @(posedge clk);
        #1 cpu_wr = 0;
        chk_chr(14'h1000, 'h30*1024, "R12");

        // R7 mirroring
        do_write(16'h7EF7, 8'h01);
        chk_nt(14'h2400, 1, "R7");
        chk_nt(14'h2800, 0, "R7");
        chk_nt(14'h2C00, 1, "R7");
        do_write(16'h7EF6, 8'h00);
        chk_nt(14'h2400, 0, "R7");
        chk_nt(14'h2800, 1, "R7");

        // R9 key, R10 gating
        do_write(16'h7EF8, 8'hA2);
        chk_ram(16'h7F10, 1, 0, 0, 0, "R9");
        do_write(16'h7EF9, 8'hA3);
        chk_ram(16'h7F85, 1, 0, 1, 0, "R10");
        chk_ram(16'h7F05, 0, 1, 1, 1, "R10");
        chk_ram(16'h7E10, 1, 0, 0, 0, "R10");
        chk_ram(16'h7F20, 0, 0, 0, 0, "R10");
        do_write(16'h7EF8, 8'h00);
        chk_ram(16'h7F20, 0, 1, 0, 0, "R9");

        // R11 reset relocks, then R8 alternate mirroring
        do_write(16'h7EF8, 8'hA3);
        chk_ram(16'h7F01, 1, 0, 1, 0, "R9");
        do_reset(1);
        chk_ram(16'h7F01, 1, 0, 0, 0, "R11");
        chk_chr(14'h0400, 'h0400, "R11");
        do_write(16'h7EF0, 8'h80);
        do_write(16'h7EF1, 8'h00);
        chk_nt(14'h2000, 1, "R8");
        chk_nt(14'h2400, 1, "R8");
        chk_nt(14'h2800, 0, "R8");
        chk_nt(14'h2C00, 0, "R8");
        chk_chr(14'h0000, 0, "R6");
        chk_chr(14'h0400, 'h0400, "R6");
        do_write(16'h7EF6, 8'h01);
        chk_nt(14'h2C00, 0, "R8");
        chk_nt(14'h2400, 1, "R8");
        do_write(16'h7EF1, 8'h80);
        chk_nt(14'h2C00, 1, "R8");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule